// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block runs one I2C master transaction at the level of whole bytes. A host posts a start request with a direction and a mode, and may post a stop request. The block then sends bus commands one at a time to an external bit engine: start plus address, write byte, read byte and stop. It uses the acknowledge that comes back for each command to decide the next step. Bytes pass between the host and the bus through a small shared buffer. The host fills it with push strobes when transmitting and empties it with pop strobes when receiving.

There are two modes. In counted mode the transfer ends when a programmed byte count runs out. If a stop is pending at that point, the bus is released. If not, an access-done pulse is raised and the bus stays held, so the host can issue a repeated start or a later stop. In repeat mode the count is ignored: the block keeps moving bytes as buffer space and data allow until a stop is posted. A missing acknowledge on the address or on any written byte ends the transfer. The block signals it and then releases the bus.

Top module: `i2cXferSeq`

## Requirements
- R1: After reset, cmdValid, busBusy, txReady, rxReady, accessDone and nackEvent are 0 and remainCount is 0.
- R2: A startReq pulse is ignored while enable is 0. With enable at 1 it loads remainCount from the programmed count, empties the buffer and issues command code 0 (start) with cmdData = {slaveAddr, rnw}, where rnw is 1 for receive (dirTx = 0).
- R3: In counted transmit mode, each pushed byte is sent in push order as command code 1 (write), one per counted byte. txReady is 1 while the bus is held, the buffer has room and bytes remain.
- R4: In counted receive mode, command code 2 (read) is issued while the count is nonzero and the buffer holds fewer than 4 bytes. Received bytes pop out in arrival order, and rxReady is 1 while the buffer holds any received byte.
- R5: When the count reaches zero with a stop pending, command code 3 (stop) is issued. After its response busBusy returns to 0 and remainCount shows the programmed count again.
- R6: When the count reaches zero with no stop pending, accessDone pulses for one cycle, the bus stays held with no command, and a later stopReq issues the stop command.
- R7: In repeat mode the count is ignored. Transmit sends every pushed byte, and receive fills the buffer to 4 bytes and then waits.
- R8: In repeat mode a pending stop request is served before any further byte command.
- R9: A response with respAck = 0 to the start or to a write raises a one-cycle nackEvent, drops the pending stop, sends no further write and issues the stop command.
- R10: remainCount shows the current remaining count. It falls by one per completed byte response, not on issue.
- R11: At most one command is outstanding. cmdValid stays 0 until the response to the previous command, and cmdOp and cmdData stay stable while cmdValid waits for cmdReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows start requests |
| startReq | input | 1 | Start (or repeated start) pulse |
| stopReq | input | 1 | Stop request pulse; held pending |
| dirTx | input | 1 | 1 = transmit, 0 = receive; latched at start |
| repeatMode | input | 1 | 1 = ignore count; latched at start |
| slaveAddr | input | 7 | 7-bit target address |
| countWrite | input | 1 | Loads the programmed count |
| countValue | input | 16 | Programmed byte count |
| remainCount | output | 16 | Current remaining count |
| pushStrobe | input | 1 | Host pushes a transmit byte |
| pushData | input | 8 | Byte to push |
| popStrobe | input | 1 | Host pops a received byte |
| popData | output | 8 | Oldest buffered byte |
| txReady | output | 1 | Buffer accepts a transmit byte |
| rxReady | output | 1 | A received byte is available |
| accessDone | output | 1 | Pulse: count done, bus held |
| nackEvent | output | 1 | Pulse: no acknowledge received |
| busBusy | output | 1 | Transaction in progress |
| cmdValid | output | 1 | Command to bit engine valid |
| cmdReady | input | 1 | Bit engine accepts command |
| cmdOp | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmdData | output | 8 | Address byte or byte to write |
| respValid | input | 1 | Bit engine finished the command |
| respAck | input | 1 | Acknowledge of the finished command |
| respData | input | 8 | Byte read by the bit engine |

## Verification
The bench uses the default parameters: a 4-byte buffer, a 16-bit count and 8-bit bytes. The small buffer depth makes the fill-and-wait limit of receive easy to reach, together with the point where remainCount stops partway through a transfer. The bit-engine model adds random delays of 0 to 2 cycles before it accepts a command and before it responds, so the stall paths of the handshake are exercised. Its acknowledge plan can refuse the address or any chosen write. The 16-bit count is used only with small values, so the count-exhaustion paths are reached in a few dozen cycles.

// File: rtl/i2cXferSeqPkg.sv
package i2cXferSeqPkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } busOp_e;

  typedef struct packed {
    logic flush;
    logic popTx;
    logic pushRx;
    logic loadCount;
    logic decCount;
  } dpStrobe_t;
endpackage

// File: rtl/i2cXferSeqData.sv
module i2cXferSeqData
  import i2cXferSeqPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 16,
  parameter int DEPTH   = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               txMode,
  input  logic               hostPush,
  input  logic [DATA_W-1:0]  hostPushData,
  input  logic               hostPop,
  input  logic [DATA_W-1:0]  rxByte,
  input  logic               countWrite,
  input  logic [COUNT_W-1:0] countValue,
  output logic [LVL_W-1:0]   level,
  output logic [DATA_W-1:0]  headByte,
  output logic [COUNT_W-1:0] remain
);
  logic [DEPTH-1:0][DATA_W-1:0] slotBus;
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [COUNT_W-1:0] countReg;

  wire full   = level == LVL_W'(DEPTH);
  wire empty  = level == '0;
  wire doPush = !full && (txMode ? hostPush : strobe.pushRx);
  wire doPop  = !empty && (txMode ? strobe.popTx : hostPop);
  wire [DATA_W-1:0] pushVal = txMode ? hostPushData : rxByte;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic [DATA_W-1:0] slot;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slot <= '0;
      else if (doPush && !strobe.flush && wrPtr == PTR_W'(i)) slot <= pushVal;
    end
    assign slotBus[i] = slot;
  end

  assign headByte = slotBus[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else if (strobe.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= '0;
      remain   <= '0;
    end else begin
      if (countWrite) countReg <= countValue;
      if (strobe.loadCount) remain <= countReg;
      else if (strobe.decCount && remain != '0) remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/i2cXferSeqCtrl.sv
module i2cXferSeqCtrl
  import i2cXferSeqPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int COUNT_W = 16,
  parameter int DEPTH   = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               startReq,
  input  logic               stopReq,
  input  logic               dirTx,
  input  logic               repeatMode,
  input  logic [ADDR_W-1:0]  slaveAddr,
  input  logic [LVL_W-1:0]   level,
  input  logic [DATA_W-1:0]  headByte,
  input  logic [COUNT_W-1:0] remain,
  input  logic               cmdReady,
  input  logic               respValid,
  input  logic               respAck,
  output dpStrobe_t          strobe,
  output logic               txMode,
  output logic               cmdValid,
  output logic [1:0]         cmdOp,
  output logic [DATA_W-1:0]  cmdData,
  output logic               txReady,
  output logic               rxReady,
  output logic               accessDone,
  output logic               nackEvent,
  output logic               busBusy
);
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WAIT, S_RUN, S_HOLD} state_e;

  state_e state, nState;
  busOp_e op, nOp;
  logic [DATA_W-1:0] opData, nData;
  logic txLat, nTx, repLat, nRep, stopPend, nStop, nAcc, nNack;

  wire roomLeft = level < LVL_W'(DEPTH);
  wire hasByte  = level != '0;

  always_comb begin
    nState = state;
    nOp    = op;
    nData  = opData;
    nTx    = txLat;
    nRep   = repLat;
    nStop  = stopPend | stopReq;
    nAcc   = 1'b0;
    nNack  = 1'b0;
    strobe = '0;
    case (state)
      S_IDLE, S_HOLD: begin
        if (startReq && enable) begin
          nTx = dirTx;
          nRep = repeatMode;
          strobe.flush = 1'b1;
          strobe.loadCount = 1'b1;
          nState = S_CMD;
          nOp = OP_START;
          nData = DATA_W'({slaveAddr, ~dirTx});
        end else if (state == S_HOLD && nStop) begin
          nStop = 1'b0;
          strobe.flush = txLat;
          nState = S_CMD;
          nOp = OP_STOP;
          nData = '0;
        end
      end
      S_CMD: begin
        if (cmdReady) begin
          nState = S_WAIT;
          strobe.popTx = (op == OP_WRITE);
        end
      end
      S_WAIT: begin
        if (respValid) begin
          nState = S_RUN;
          case (op)
            OP_READ:  begin strobe.pushRx = 1'b1; strobe.decCount = !repLat; end
            OP_WRITE: strobe.decCount = !repLat;
            OP_STOP:  begin nState = S_IDLE; strobe.loadCount = 1'b1; strobe.flush = txLat; end
            default:  ;
          endcase
          if ((op == OP_START || op == OP_WRITE) && !respAck) begin
            nNack = 1'b1;
            nStop = 1'b0;
            strobe.flush = txLat;
            nState = S_CMD;
            nOp = OP_STOP;
            nData = '0;
          end
        end
      end
      S_RUN: begin
        if ((repLat || remain == '0) && nStop) begin
          nStop = 1'b0;
          strobe.flush = txLat;
          nState = S_CMD;
          nOp = OP_STOP;
          nData = '0;
        end else if (!repLat && remain == '0) begin
          nAcc = 1'b1;
          nState = S_HOLD;
        end else if (txLat && hasByte) begin
          nState = S_CMD;
          nOp = OP_WRITE;
          nData = headByte;
        end else if (!txLat && roomLeft) begin
          nState = S_CMD;
          nOp = OP_READ;
          nData = '0;
        end
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      op <= OP_START;
      opData <= '0;
      txLat <= 1'b0;
      repLat <= 1'b0;
      stopPend <= 1'b0;
      accessDone <= 1'b0;
      nackEvent <= 1'b0;
    end else begin
      state <= nState;
      op <= nOp;
      opData <= nData;
      txLat <= nTx;
      repLat <= nRep;
      stopPend <= nStop;
      accessDone <= nAcc;
      nackEvent <= nNack;
    end
  end

  assign txMode   = txLat;
  assign cmdValid = state == S_CMD;
  assign cmdOp    = op;
  assign cmdData  = opData;
  assign busBusy  = state != S_IDLE;
  assign txReady  = txLat && (state == S_RUN || state == S_CMD || state == S_WAIT)
                    && op != OP_STOP && roomLeft && (repLat || remain != '0);
  assign rxReady  = !txLat && hasByte;
endmodule

// File: rtl/i2cXferSeq.sv
module i2cXferSeq
  import i2cXferSeqPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int COUNT_W = 16,
  parameter int DEPTH   = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               startReq,
  input  logic               stopReq,
  input  logic               dirTx,
  input  logic               repeatMode,
  input  logic [ADDR_W-1:0]  slaveAddr,
  input  logic               countWrite,
  input  logic [COUNT_W-1:0] countValue,
  output logic [COUNT_W-1:0] remainCount,
  input  logic               pushStrobe,
  input  logic [DATA_W-1:0]  pushData,
  input  logic               popStrobe,
  output logic [DATA_W-1:0]  popData,
  output logic               txReady,
  output logic               rxReady,
  output logic               accessDone,
  output logic               nackEvent,
  output logic               busBusy,
  output logic               cmdValid,
  input  logic               cmdReady,
  output logic [1:0]         cmdOp,
  output logic [DATA_W-1:0]  cmdData,
  input  logic               respValid,
  input  logic               respAck,
  input  logic [DATA_W-1:0]  respData
);
  dpStrobe_t strobe;
  logic txMode;
  logic [LVL_W-1:0] level;

  i2cXferSeqCtrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .startReq(startReq), .stopReq(stopReq),
    .dirTx(dirTx), .repeatMode(repeatMode), .slaveAddr(slaveAddr), .level(level),
    .headByte(popData), .remain(remainCount), .cmdReady(cmdReady), .respValid(respValid),
    .respAck(respAck), .strobe(strobe), .txMode(txMode), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdData(cmdData), .txReady(txReady), .rxReady(rxReady),
    .accessDone(accessDone), .nackEvent(nackEvent), .busBusy(busBusy)
  );

  i2cXferSeqData #(.DATA_W(DATA_W), .COUNT_W(COUNT_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txMode(txMode), .hostPush(pushStrobe),
    .hostPushData(pushData), .hostPop(popStrobe), .rxByte(respData),
    .countWrite(countWrite), .countValue(countValue), .level(level),
    .headByte(popData), .remain(remainCount)
  );
endmodule

// File: rtl/i2cXferSeqChecker.sv
module i2cXferSeqChecker #(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               startReq,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [1:0]         cmdOp,
  input logic [DATA_W-1:0]  cmdData,
  input logic               respValid,
  input logic               respAck,
  input logic               nackEvent,
  input logic               accessDone,
  input logic               busBusy,
  input logic [COUNT_W-1:0] remainCount
);
  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOp) && $stable(cmdData));

  assert_nack_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    nackEvent |-> $past(respValid && !respAck));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> $past(respValid));

  assert_access_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    accessDone |-> busBusy && !cmdValid);

  assert_remain_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    busBusy && $past(busBusy) && !$past(startReq) && (remainCount < $past(remainCount))
    |-> (remainCount == $past(remainCount) - COUNT_W'(1)) && $past(respValid));
endmodule

bind i2cXferSeq i2cXferSeqChecker #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) uChecker (
  .clk(clk), .rstN(rstN), .startReq(startReq), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdOp(cmdOp), .cmdData(cmdData), .respValid(respValid), .respAck(respAck),
  .nackEvent(nackEvent), .accessDone(accessDone), .busBusy(busBusy),
  .remainCount(remainCount)
);

// File: tb/test_i2cXferSeq.sv
`timescale 1ns/1ps
module test_i2cXferSeq;
  logic clk = 1'b0, rstN = 1'b0;
  logic enable = 0, startReq = 0, stopReq = 0, dirTx = 0, repeatMode = 0;
  logic [6:0] slaveAddr = 7'h5A;
  logic countWrite = 0;
  logic [15:0] countValue = 0, remainCount;
  logic pushStrobe, popStrobe;
  logic [7:0] pushData, popData, cmdData, respData;
  logic txReady, rxReady, accessDone, nackEvent, busBusy, cmdValid, cmdReady;
  logic respValid, respAck;
  logic [1:0] cmdOp;

  i2cXferSeq i_i2cXferSeq (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int logOp[256], logData[256];
  int logN = 0, nackAt = -1, rdSeq = 0, thisIdx = 0, overlap = 0;
  int txBytes[16];
  int txLeft = 0, txIdx = 0;
  bit autoPop = 0;
  int rxGot[64];
  int rxN = 0, accCnt = 0, nackCnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int countOp(input int opc);
    int n = 0;
    for (int i = 0; i < logN; i++) if (logOp[i] == opc) n++;
    return n;
  endfunction

  function automatic int startByte(input bit rx);
    return (int'(slaveAddr) << 1) | int'(rx);
  endfunction

  // bit engine model
  initial begin
    cmdReady = 0; respValid = 0; respAck = 0; respData = 0;
    forever begin
      @(negedge clk);
      if (cmdValid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        thisIdx = logN;
        logOp[logN] = cmdOp; logData[logN] = cmdData; logN++;
        cmdReady = 1;
        @(negedge clk);
        cmdReady = 0;
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          if (cmdValid) overlap++;
        end
        if (cmdValid) overlap++;
        respValid = 1;
        respAck = (thisIdx != nackAt);
        respData = 8'h30 + 8'(rdSeq);
        if (logOp[thisIdx] == 2) rdSeq++;
        @(negedge clk);
        respValid = 0;
      end
    end
  end

  // host side of the buffer and event counters
  initial begin
    pushStrobe = 0; popStrobe = 0; pushData = 0;
    forever begin
      @(negedge clk);
      pushStrobe = 0; popStrobe = 0;
      if (accessDone) accCnt++;
      if (nackEvent) nackCnt++;
      if (txLeft > 0 && txReady) begin
        pushStrobe = 1; pushData = 8'(txBytes[txIdx]); txIdx++; txLeft--;
      end
      if (autoPop && rxReady) begin
        popStrobe = 1; rxGot[rxN] = popData; rxN++;
      end
    end
  end

  task automatic clearLog();
    logN = 0; rdSeq = 0; accCnt = 0; nackCnt = 0; rxN = 0; txIdx = 0; txLeft = 0;
    nackAt = -1; overlap = 0;
  endtask

  task automatic setCount(input int v);
    @(negedge clk); countWrite = 1; countValue = 16'(v);
    @(negedge clk); countWrite = 0;
  endtask

  task automatic pulseStart(input bit tx, input bit rep, input bit stp);
    @(negedge clk); dirTx = tx; repeatMode = rep; startReq = 1; stopReq = stp;
    @(negedge clk); startReq = 0; stopReq = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopReq = 1;
    @(negedge clk); stopReq = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000 && busBusy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!cmdValid && !busBusy && !txReady && !rxReady && !accessDone && !nackEvent,
          "R1 reset outputs", {cmdValid, busBusy, txReady, rxReady, accessDone, nackEvent}, 0);
    check(remainCount == 0, "R1 reset count", remainCount, 0);
    rstN = 1;
    void'($urandom(32'h1234));

    // R2: start ignored while disabled
    clearLog(); setCount(3); pulseStart(1, 0, 1);
    repeat (10) @(negedge clk);
    check(logN == 0 && !busBusy, "R2 start ignored when disabled", logN, 0);
    enable = 1;

    // R3/R5: counted transmit with stop, random lengths
    for (int it = 0; it < 3; it++) begin
      clearLog();
      n = $urandom_range(1, 7);
      for (int i = 0; i < n; i++) txBytes[i] = $urandom_range(0, 255);
      setCount(n); txLeft = n; pulseStart(1, 0, 1); waitIdle();
      check(logN == n + 2, "R3 command count", logN, n + 2);
      check(logOp[0] == 0 && logData[0] == startByte(0), "R2 start address byte", logData[0], startByte(0));
      for (int i = 0; i < n; i++)
        check(logOp[i+1] == 1 && logData[i+1] == txBytes[i], "R3 write byte order", logData[i+1], txBytes[i]);
      check(logOp[n+1] == 3 && !busBusy, "R5 stop issued and bus released", logOp[n+1], 3);
      check(remainCount == n && accCnt == 0, "R5 count reloaded", remainCount, n);
      check(overlap == 0, "R11 single outstanding command", overlap, 0);
    end

    // R4: counted receive with stop
    for (int it = 0; it < 3; it++) begin
      clearLog(); autoPop = 1;
      n = $urandom_range(1, 9);
      setCount(n); pulseStart(0, 0, 1); waitIdle();
      repeat (10) @(negedge clk);
      check(logN == n + 2 && countOp(2) == n, "R4 read command count", countOp(2), n);
      check(logData[0] == startByte(1), "R2 receive address byte", logData[0], startByte(1));
      check(rxN == n, "R4 bytes popped", rxN, n);
      for (int i = 0; i < rxN; i++)
        check(rxGot[i] == 8'h30 + i, "R4 receive order", rxGot[i], 8'h30 + i);
      autoPop = 0;
    end

    // R4/R10/R6: buffer limit, live count, access done without stop
    clearLog(); setCount(6); pulseStart(0, 0, 0);
    repeat (60) @(negedge clk);
    check(countOp(2) == 4 && rxReady, "R4 buffer holds at most 4", countOp(2), 4);
    check(remainCount == 2, "R10 remaining count mid transfer", remainCount, 2);
    autoPop = 1;
    for (int i = 0; i < 300 && accCnt == 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(accCnt == 1 && busBusy && !cmdValid, "R6 access done keeps bus", accCnt, 1);
    check(remainCount == 0, "R10 count at zero", remainCount, 0);
    pulseStop(); waitIdle();
    check(logOp[logN-1] == 3 && !busBusy && rxN == 6, "R6 later stop issued", logOp[logN-1], 3);
    autoPop = 0;

    // R9: address not acknowledged
    clearLog(); nackAt = 0;
    for (int i = 0; i < 3; i++) txBytes[i] = i + 1;
    setCount(3); txLeft = 3; pulseStart(1, 0, 1); waitIdle(); txLeft = 0;
    check(nackCnt == 1 && logN == 2 && logOp[1] == 3, "R9 address nack then stop", logN, 2);

    // R9: data byte not acknowledged
    clearLog(); nackAt = 3;
    for (int i = 0; i < 5; i++) txBytes[i] = 8'hC0 + i;
    setCount(5); txLeft = 5; pulseStart(1, 0, 1); waitIdle(); txLeft = 0;
    check(nackCnt == 1 && countOp(1) == 3, "R9 no write after nack", countOp(1), 3);
    check(logOp[logN-1] == 3 && !busBusy && accCnt == 0, "R9 stop after data nack", logOp[logN-1], 3);

    // R7: repeat transmit ignores count
    clearLog();
    for (int i = 0; i < 6; i++) txBytes[i] = $urandom_range(0, 255);
    setCount(0); txLeft = 6; pulseStart(1, 1, 0);
    repeat (80) @(negedge clk);
    check(countOp(1) == 6 && busBusy && accCnt == 0, "R7 repeat sends all bytes", countOp(1), 6);
    for (int i = 0; i < 6; i++)
      check(logData[i+1] == txBytes[i], "R7 repeat byte order", logData[i+1], txBytes[i]);
    pulseStop(); waitIdle();
    check(logN == 8 && logOp[7] == 3, "R8 stop served in repeat", logN, 8);

    // R7/R8: repeat receive fills buffer, stop first
    clearLog(); setCount(1); pulseStart(0, 1, 0);
    repeat (60) @(negedge clk);
    check(countOp(2) == 4 && rxReady && busBusy, "R7 repeat receive fills to 4", countOp(2), 4);
    pulseStop(); waitIdle();
    check(logN == 6 && logOp[5] == 3, "R8 stop before more reads", logN, 6);
    autoPop = 1; repeat (10) @(negedge clk); autoPop = 0;
    check(rxN == 4 && rxGot[3] == 8'h33, "R7 repeat receive data", rxN, 4);
    check(overlap == 0, "R11 single outstanding command", overlap, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule